// File: doc/BRIEF.md
# Branch Trace Buffer with Loop Compression

This block records the recent history of program-flow changes for a processor core. Each time the core takes a non-sequential jump it presents a pair of program counters, the address it jumped from and the address it landed on. The block keeps up to sixteen such pairs in a circular store. It can also fold repeated iterations of a loop into an existing entry, so the loop does not fill the store. In that case it marks bit 0 of the matching entry instead of adding a new one.

Software works through three registers on a simple synchronous bus: a control word, an occupancy count and a data port. The data port hands out the newest entry first. The first read gives the landing address and the second read gives the origin address and removes the entry. When the store is full, the control word chooses between two behaviours. In one the oldest pair is dropped silently. In the other the new pair is refused and a one-cycle overflow-exception pulse goes to the core's event logic. The core supplies its current event level, because capture is suppressed at some levels.

Top module: `branch_trace_buf`

## Requirements
- R1: After reset the control word, the occupancy count and the data port all read 0, and `ovf_exc` is low.
- R2: A branch (`br_valid` high) is stored only when control bit 0 (power) and control bit 1 (enable) are both 1. A branch flagged `br_hwloop` is never stored.
- R3: No branch is stored while `evt_level` is 1. While `evt_level` is 0, 2 or 3 and control bit 2 (overflow exception) is 1, no branch is stored either. At any other level the branch is stored.
- R4: Suppose the store holds 16 entries, control bit 2 is 1 and a branch is stored. The branch is discarded, the contents stay unchanged and `ovf_exc` is high for exactly the one cycle after the capture cycle.
- R5: Suppose the store holds 16 entries and control bit 2 is 0. A new branch replaces the oldest entry and the count stays at 16.
- R6: With control bit 3 (one-level compression) set and at least one entry present, a new pair is compared with the newest entry, ignoring bit 0 of each address. If they match, nothing is stored and bit 0 of the newest entry's landing address is set to 1.
- R7: With control bit 4 (two-level compression) set and at least two entries present, a pair that fails the one-level check is compared with the second-newest entry, ignoring bit 0. If they match, nothing is stored and bit 0 of that entry's origin address is set to 1.
- R8: Full handling comes before compression. With the store full and control bit 2 at 0, a compressed branch still drops the oldest entry, so the count falls to 15.
- R9: Reading the data port (offset 0x100) when the store is empty returns 0. Otherwise reads alternate between the newest landing address and then its origin address, and the second read removes the entry. Read data appears on `bus_rdata` in the cycle after `bus_re`.
- R10: Reading offset 0x004 returns the number of stored entries, limited to 16.
- R11: The control word at offset 0x000 keeps bits [4:0] and reads 0 in all higher bits. Writes to offsets 0x004 and 0x100 have no effect.
- R12: When a capture and a data-port read occur in the same cycle, the capture is applied first and the read sees its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A flow change is presented this cycle |
| br_src | input | 32 | Address the flow change left from |
| br_dst | input | 32 | Address the flow change went to |
| br_hwloop | input | 1 | Flow change comes from a zero-overhead hardware loop |
| evt_level | input | 4 | Current core event level (0 emulation, 1 reset, 2 NMI, 3 exception, 4 and up lower) |
| bus_addr | input | 9 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, valid the cycle after `bus_re` |
| ovf_exc | output | 1 | One-cycle overflow-exception pulse |

## Verification
The bench walks a compression sequence in which the second-level match only happens because the first-level match fails. A design that checks the levels in the wrong order would mark the wrong entry, and the tagged bit 0 would then show up in the wrong read. It fills the store past capacity in both overflow modes. A design that lets the pointer wrap wrongly would return a stale oldest pair, and a design that checks for a full store after compression would report 16 instead of 15 in the combined full-and-compressed case. It also reads the data port in the same cycle as a capture into an empty store. A design that resolves the read first would return 0 instead of the new landing address.

// File: rtl/brtrace_pkg.sv
// Shared constants for the branch trace buffer: register offsets,
// control-bit positions and the event-level codes the gating depends on.
package brtrace_pkg;
    localparam int ADDR_W  = 9;
    localparam int LVL_W   = 4;
    localparam int CTRL_W  = 5;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 9'h000;
    localparam logic [ADDR_W-1:0] OFF_STAT = 9'h004;
    localparam logic [ADDR_W-1:0] OFF_DATA = 9'h100;

    localparam int CB_PWR  = 0;
    localparam int CB_EN   = 1;
    localparam int CB_OVF  = 2;
    localparam int CB_CMP1 = 3;
    localparam int CB_CMP2 = 4;

    localparam logic [LVL_W-1:0] LVL_RESET = 4'd1;
    localparam logic [LVL_W-1:0] LVL_EXCPT = 4'd3;
endpackage

// File: rtl/brtrace_qual.sv
// Decides whether a presented flow change may enter the store.
// Assumes: ctrl is the registered control word; purely combinational.
module brtrace_qual
    import brtrace_pkg::*;
(
    input  logic [CTRL_W-1:0] ctrl,
    input  logic              br_valid,
    input  logic              br_hwloop,
    input  logic [LVL_W-1:0]  evt_level,
    output logic              cap
);
    logic armed;
    logic lvl_block;

    // Capture needs power and enable, a non-loop branch and an allowed level.
    always_comb begin
        armed     = ctrl[CB_PWR] && ctrl[CB_EN];
        lvl_block = (evt_level == LVL_RESET) ||
                    ((evt_level <= LVL_EXCPT) && ctrl[CB_OVF]);
        cap       = br_valid && armed && !br_hwloop && !lvl_block;
    end
endmodule

// File: rtl/brtrace_store.sv
// Circular store of origin/landing address pairs, read newest-first.
// Handles a full store (refuse or overwrite), one- and two-level compression,
// and the two-read pop. The capture is resolved before a same-cycle pop.
// Assumes: DEPTH is a power of two; slot storage has no reset because an
// empty store never exposes it.
module brtrace_store #(
    parameter  int DEPTH = 16,
    parameter  int PC_W  = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [PC_W-1:0]  cap_src,
    input  logic [PC_W-1:0]  cap_dst,
    input  logic             ovf_en,
    input  logic             cmp1_en,
    input  logic             cmp2_en,
    input  logic             pop,
    output logic [CNT_W-1:0] occ,
    output logic [CNT_W-1:0] occ_eff,
    output logic [PC_W-1:0]  rd_word,
    output logic             exc_raise
);
    logic [PC_W-1:0]  slot_src [DEPTH];
    logic [PC_W-1:0]  slot_dst [DEPTH];
    logic [IDX_W-1:0] top_q;
    logic [CNT_W-1:0] cnt_q;
    logic             half_q;

    logic [IDX_W-1:0] idx_last, idx_prev, top_b;
    logic             full, go, hit1, hit2, push;
    logic [CNT_W-1:0] cnt_a, cnt_b;
    logic [PC_W-1:0]  new_src, new_dst;

    // Resolve the capture: full handling, then compression, then push.
    always_comb begin
        idx_last  = top_q - IDX_W'(1);
        idx_prev  = top_q - IDX_W'(2);
        full      = (cnt_q == CNT_W'(DEPTH));
        exc_raise = cap && full && ovf_en;
        go        = cap && !exc_raise;
        cnt_a     = (go && full) ? cnt_q - CNT_W'(1) : cnt_q;
        hit1      = go && cmp1_en && (cnt_q >= CNT_W'(1)) &&
                    (cap_src[PC_W-1:1] == slot_src[idx_last][PC_W-1:1]) &&
                    (cap_dst[PC_W-1:1] == slot_dst[idx_last][PC_W-1:1]);
        hit2      = go && !hit1 && cmp2_en && (cnt_q >= CNT_W'(2)) &&
                    (cap_src[PC_W-1:1] == slot_src[idx_prev][PC_W-1:1]) &&
                    (cap_dst[PC_W-1:1] == slot_dst[idx_prev][PC_W-1:1]);
        push      = go && !hit1 && !hit2;
        cnt_b     = push ? cnt_a + CNT_W'(1) : cnt_a;
        top_b     = push ? top_q + IDX_W'(1) : top_q;
        new_src   = push ? cap_src : slot_src[idx_last];
        new_dst   = push ? cap_dst : (slot_dst[idx_last] | PC_W'(hit1));
        rd_word   = (cnt_b == '0) ? '0 : (half_q ? new_src : new_dst);
        occ       = cnt_q;
        occ_eff   = cnt_b;
    end

    // Write a pushed pair into its slot or tag bit 0 of a compressed entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push && top_q == IDX_W'(i)) begin
                slot_src[i] <= cap_src;
                slot_dst[i] <= cap_dst;
            end else begin
                if (hit1 && idx_last == IDX_W'(i)) slot_dst[i][0] <= 1'b1;
                if (hit2 && idx_prev == IDX_W'(i)) slot_src[i][0] <= 1'b1;
            end
        end
    end

    // Advance pointer, count and half-read flag, applying a pop after capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q  <= '0;
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else begin
            top_q <= top_b;
            cnt_q <= cnt_b;
            if (pop && cnt_b != '0) begin
                if (half_q) begin
                    top_q  <= top_b - IDX_W'(1);
                    cnt_q  <= cnt_b - CNT_W'(1);
                    half_q <= 1'b0;
                end else begin
                    half_q <= 1'b1;
                end
            end
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH)); // R10
    AST_EXC_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        exc_raise |=> cnt_q <= $past(cnt_q)); // R4
    AST_OVERWRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && full && !ovf_en && !cmp1_en && !cmp2_en && !pop) |=> cnt_q == CNT_W'(DEPTH)); // R5
    AST_HIT_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !full && cmp1_en && cnt_q != '0 && !pop &&
         cap_src[PC_W-1:1] == slot_src[top_q - IDX_W'(1)][PC_W-1:1] &&
         cap_dst[PC_W-1:1] == slot_dst[top_q - IDX_W'(1)][PC_W-1:1])
        |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/branch_trace_buf.sv
// Branch trace buffer top: control register, bus decode, registered read
// data and the overflow-exception pulse around the qualifier and the store.
// Assumes: one bus access per cycle; read data is returned one cycle later
// and held until the next read.
module branch_trace_buf
    import brtrace_pkg::*;
#(
    parameter  int DEPTH    = 16,
    parameter  int PC_W     = 32,
    parameter  int STAT_MAX = 16,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [PC_W-1:0]   br_src,
    input  logic [PC_W-1:0]   br_dst,
    input  logic              br_hwloop,
    input  logic [LVL_W-1:0]  evt_level,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [PC_W-1:0]   bus_wdata,
    output logic [PC_W-1:0]   bus_rdata,
    output logic              ovf_exc
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              cap, pop, exc_raise;
    logic [CNT_W-1:0]  occ, occ_eff;
    logic [PC_W-1:0]   rd_word, rd_mux, occ_ext;
    logic              unused_wbits;

    assign unused_wbits = ^bus_wdata[PC_W-1:CTRL_W];
    assign pop          = bus_re && (bus_addr == OFF_DATA);

    brtrace_qual u_qual (
        .ctrl      (ctrl_q),
        .br_valid  (br_valid),
        .br_hwloop (br_hwloop),
        .evt_level (evt_level),
        .cap       (cap)
    );

    brtrace_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap       (cap),
        .cap_src   (br_src),
        .cap_dst   (br_dst),
        .ovf_en    (ctrl_q[CB_OVF]),
        .cmp1_en   (ctrl_q[CB_CMP1]),
        .cmp2_en   (ctrl_q[CB_CMP2]),
        .pop       (pop),
        .occ       (occ),
        .occ_eff   (occ_eff),
        .rd_word   (rd_word),
        .exc_raise (exc_raise)
    );

    // Select the register addressed by a read, saturating the count.
    always_comb begin
        occ_ext = PC_W'(occ_eff);
        unique case (bus_addr)
            OFF_CTRL: rd_mux = PC_W'(ctrl_q);
            OFF_STAT: rd_mux = (occ_ext > PC_W'(STAT_MAX)) ? PC_W'(STAT_MAX) : occ_ext;
            OFF_DATA: rd_mux = rd_word;
            default:  rd_mux = '0;
        endcase
    end

    // Hold the control word, the read data and the exception pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            bus_rdata <= '0;
            ovf_exc   <= 1'b0;
        end else begin
            if (bus_we && bus_addr == OFF_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (bus_re) bus_rdata <= rd_mux;
            ovf_exc <= exc_raise;
        end
    end

    AST_NO_CAPTURE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ctrl_q[CB_PWR] && ctrl_q[CB_EN]) && !pop) |=> $stable(occ)); // R2
    AST_RESET_LEVEL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_level == LVL_RESET && !pop) |=> $stable(occ)); // R3
    AST_EXC_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> $past(occ) == CNT_W'(DEPTH)); // R4
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && occ_eff == '0) |=> bus_rdata == '0); // R9
    AST_STATUS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == OFF_STAT) |=> bus_rdata <= PC_W'(STAT_MAX)); // R10
endmodule

// File: tb/branch_trace_buf_bench.sv
`timescale 1ns/1ps
module branch_trace_buf_bench;
    localparam real HALF = 2.5;
    localparam logic [8:0] A_CTRL = 9'h000, A_STAT = 9'h004, A_DATA = 9'h100;
    localparam logic [1:0] OP_CAP = 2'd0, OP_DATA = 2'd1, OP_STAT = 2'd2, OP_CTRL = 2'd3;
    localparam int NVEC = 34;
    // Fields: [69:66] requirement number, [65:64] op, [63:32] a, [31:0] b.
    // OP_CAP: a=origin, b=landing. OP_DATA/OP_STAT: b=expected. OP_CTRL: a=value.
    localparam logic [69:0] VEC [NVEC] = '{
        {4'd6,  OP_CTRL, 32'h1B,  32'h0},   // both compressions on
        {4'd6,  OP_CAP,  32'h100, 32'h200},
        {4'd6,  OP_CAP,  32'h100, 32'h200}, // R6 folds into newest
        {4'd6,  OP_STAT, 32'h0,   32'd1},
        {4'd7,  OP_CAP,  32'h300, 32'h400},
        {4'd7,  OP_CAP,  32'h100, 32'h200}, // R7 folds into second newest
        {4'd7,  OP_STAT, 32'h0,   32'd2},
        {4'd6,  OP_CAP,  32'h300, 32'h400},
        {4'd6,  OP_STAT, 32'h0,   32'd2},
        {4'd9,  OP_DATA, 32'h0,   32'h401}, // R9 newest landing first
        {4'd9,  OP_DATA, 32'h0,   32'h300},
        {4'd6,  OP_DATA, 32'h0,   32'h201},
        {4'd7,  OP_DATA, 32'h0,   32'h101},
        {4'd9,  OP_DATA, 32'h0,   32'h0},   // empty
        {4'd10, OP_STAT, 32'h0,   32'd0},   // R10
        {4'd6,  OP_CTRL, 32'h03,  32'h0},   // compression off
        {4'd6,  OP_CAP,  32'h500, 32'h600},
        {4'd6,  OP_CAP,  32'h500, 32'h600},
        {4'd6,  OP_STAT, 32'h0,   32'd2},
        {4'd9,  OP_DATA, 32'h0,   32'h600},
        {4'd9,  OP_DATA, 32'h0,   32'h500},
        {4'd9,  OP_DATA, 32'h0,   32'h600},
        {4'd9,  OP_DATA, 32'h0,   32'h500},
        {4'd10, OP_STAT, 32'h0,   32'd0},
        {4'd7,  OP_CTRL, 32'h13,  32'h0},   // two-level only
        {4'd7,  OP_CAP,  32'h700, 32'h800},
        {4'd7,  OP_CAP,  32'h900, 32'hA00},
        {4'd7,  OP_CAP,  32'h700, 32'h800},
        {4'd7,  OP_STAT, 32'h0,   32'd2},
        {4'd7,  OP_DATA, 32'h0,   32'hA00},
        {4'd7,  OP_DATA, 32'h0,   32'h900},
        {4'd7,  OP_DATA, 32'h0,   32'h800},
        {4'd7,  OP_DATA, 32'h0,   32'h701},
        {4'd7,  OP_STAT, 32'h0,   32'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0, br_hwloop = 1'b0;
    logic [31:0] br_src = '0, br_dst = '0;
    logic [3:0]  evt_level = 4'd6;
    logic [8:0]  bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ovf_exc;
    int          n_run = 0, n_fail = 0;
    logic [31:0] rv;

    always #(HALF) clk = ~clk;

    branch_trace_buf u_branch_trace_buf (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src),
        .br_dst(br_dst), .br_hwloop(br_hwloop), .evt_level(evt_level),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_exc(ovf_exc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cap(input logic [31:0] s, input logic [31:0] d,
                       input logic hw, input logic [3:0] lvl);
        br_src = s; br_dst = d; br_hwloop = hw; evt_level = lvl; br_valid = 1'b1;
        @(negedge clk);
        br_valid = 1'b0; br_hwloop = 1'b0; evt_level = 4'd6;
    endtask

    initial begin
        #(2.0 * HALF * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 ovf", {31'b0, ovf_exc}, 32'h0);
        rd(A_CTRL, rv); check("R1 ctrl", rv, 32'h0);
        rd(A_STAT, rv); check("R1 stat", rv, 32'h0);
        rd(A_DATA, rv); check("R1 data", rv, 32'h0);

        // Table walk: compression modes, alternation, empty reads
        for (int i = 0; i < NVEC; i++) begin
            logic [69:0] v = VEC[i];
            case (v[65:64])
                OP_CAP:  cap(v[63:32], v[31:0], 1'b0, 4'd6);
                OP_CTRL: wr(A_CTRL, v[63:32]);
                OP_DATA: begin rd(A_DATA, rv); check($sformatf("R%0d vec %0d", v[69:66], i), rv, v[31:0]); end
                default: begin rd(A_STAT, rv); check($sformatf("R%0d vec %0d", v[69:66], i), rv, v[31:0]); end
            endcase
        end

        // R2 power/enable and hardware-loop gating
        do_reset();
        wr(A_CTRL, 32'h02); cap(32'h10, 32'h20, 1'b0, 4'd6);
        wr(A_CTRL, 32'h01); cap(32'h10, 32'h20, 1'b0, 4'd6);
        rd(A_STAT, rv); check("R2 no power or no enable", rv, 32'd0);
        wr(A_CTRL, 32'h03); cap(32'h10, 32'h20, 1'b1, 4'd6);
        rd(A_STAT, rv); check("R2 hwloop ignored", rv, 32'd0);
        cap(32'h10, 32'h20, 1'b0, 4'd6);
        rd(A_STAT, rv); check("R2 armed capture", rv, 32'd1);

        // R3 event-level gating
        do_reset();
        wr(A_CTRL, 32'h03); cap(32'h30, 32'h40, 1'b0, 4'd1);
        rd(A_STAT, rv); check("R3 reset level", rv, 32'd0);
        wr(A_CTRL, 32'h07); cap(32'h30, 32'h40, 1'b0, 4'd3);
        rd(A_STAT, rv); check("R3 level 3 with ovf bit", rv, 32'd0);
        wr(A_CTRL, 32'h03); cap(32'h30, 32'h40, 1'b0, 4'd3);
        rd(A_STAT, rv); check("R3 level 3 without ovf bit", rv, 32'd1);
        wr(A_CTRL, 32'h07); cap(32'h50, 32'h60, 1'b0, 4'd5);
        rd(A_STAT, rv); check("R3 level 5 with ovf bit", rv, 32'd2);

        // R11 register map and ignored writes
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd(A_CTRL, rv); check("R11 ctrl width", rv, 32'h1F);
        wr(A_STAT, 32'h55); wr(A_DATA, 32'h77);
        rd(A_STAT, rv); check("R11 status write ignored", rv, 32'd2);
        rd(A_DATA, rv); check("R11 data write ignored", rv, 32'h60);

        // R5 overwrite when full
        do_reset();
        wr(A_CTRL, 32'h03);
        for (int i = 1; i <= 17; i++) cap(32'h1000 + i * 16, 32'h2000 + i * 16, 1'b0, 4'd6);
        rd(A_STAT, rv); check("R5 count stays 16", rv, 32'd16);
        for (int i = 17; i >= 2; i--) begin
            rd(A_DATA, rv); check("R5 landing", rv, 32'h2000 + i * 16);
            rd(A_DATA, rv); check("R5 origin", rv, 32'h1000 + i * 16);
        end
        rd(A_STAT, rv); check("R5 oldest dropped", rv, 32'd0);

        // R4 refuse and raise exception when full
        do_reset();
        wr(A_CTRL, 32'h07);
        for (int i = 1; i <= 16; i++) cap(32'h1000 + i * 16, 32'h2000 + i * 16, 1'b0, 4'd6);
        check("R4 no pulse before overflow", {31'b0, ovf_exc}, 32'h0);
        cap(32'h9990, 32'h9994, 1'b0, 4'd6);
        check("R4 pulse high", {31'b0, ovf_exc}, 32'h1);
        @(negedge clk);
        check("R4 pulse one cycle", {31'b0, ovf_exc}, 32'h0);
        rd(A_STAT, rv); check("R4 count", rv, 32'd16);
        rd(A_DATA, rv); check("R4 newest kept", rv, 32'h2100);

        // R8 full handling before compression
        do_reset();
        wr(A_CTRL, 32'h0B);
        for (int i = 1; i <= 16; i++) cap(32'h1000 + i * 16, 32'h2000 + i * 16, 1'b0, 4'd6);
        cap(32'h1100, 32'h2100, 1'b0, 4'd6);
        rd(A_STAT, rv); check("R8 count 15", rv, 32'd15);
        rd(A_DATA, rv); check("R8 tagged landing", rv, 32'h2101);
        rd(A_DATA, rv); check("R8 origin", rv, 32'h1100);
        rd(A_DATA, rv); check("R8 next entry", rv, 32'h20F0);

        // R12 capture and read in the same cycle
        do_reset();
        wr(A_CTRL, 32'h03);
        br_src = 32'hA0; br_dst = 32'hB0; br_valid = 1'b1;
        bus_addr = A_DATA; bus_re = 1'b1;
        @(negedge clk);
        br_valid = 1'b0; bus_re = 1'b0;
        check("R12 capture before read", bus_rdata, 32'hB0);
        rd(A_STAT, rv); check("R12 entry kept", rv, 32'd1);
        rd(A_DATA, rv); check("R12 origin second", rv, 32'hA0);
        rd(A_STAT, rv); check("R12 popped", rv, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule